// File: doc/BRIEF.md
# Programmable Interlaced Video Sync and Blank Timing Generator

This block derives horizontal and vertical sync, horizontal and vertical blanking and an odd/even field flag for an interlaced picture from the pixel clock. A horizontal counter runs over a line of `LINE_LEN` clocks. A line counter runs over one field. The field flag flips each time a field ends. The sync pulses and the nominal blanking windows are placed by parameters.

Two byte-wide control registers are written and read back over a plain address/data/write-strobe bus. The I/O control register holds three independent output polarities: field, vertical pair and horizontal pair. It also holds two pin-direction bits, which only drive output-enable pins. The timing control register selects the field length in lines and a sign-magnitude shift of the horizontal blanking window of up to 15 clocks in either direction. A timing write is held back until the next line begins, so a blanking pulse already in progress is never cut short.

Top module: `vidTimingGen`

## Requirements
- R1: While `rstN` is low, every sync, blank and field output is 0, `syncOe` is 0, `blankOe` is 1 and both registers read 00h. After release, the first line starts at count 0 on line 0 of an odd field.
- R2: A line lasts `LINE_LEN` clocks. `hSync` is active for counts in [`HSYNC_START`, `HSYNC_START`+`HSYNC_WIDTH`). Each output reflects the count of the previous clock.
- R3: Timing register bits 4..0 shift both edges of the `HBLANK_WIDTH`-clock horizontal blanking window, modulo the line length. With bit 4 clear, the window is delayed by bits 3..0 clocks. With bit 4 set, it is advanced by bits 3..0 clocks, so code 10000 gives no shift.
- R4: Timing register bits 6..5 select the field length: 00 gives 240 lines, 01 gives 241 lines, 10 gives 242 lines and 11 gives 240 lines. A line count at or beyond the selected length minus one ends the field at the end of that line.
- R5: `vBlank` is active on lines 0 to `VBLANK_LINES`-1 of each field. `vSync` is active on lines 0 to `VSYNC_LINES`-1.
- R6: The internal field flag is odd after reset and toggles at the end of every field. With I/O register bit 4 clear, a high `field` means odd. With bit 4 set, a high `field` means even.
- R7: With I/O register bit 3 set, `vSync` and `vBlank` are inverted. With bit 2 set, `hSync` and `hBlank` are inverted. A polarity write changes the outputs from the second clock edge after the write.
- R8: A write to the timing register changes neither the blanking shift nor the field length until the next line boundary.
- R9: Address 04h reads back I/O register bits 4..0 with bits 7..5 as zero. Address 05h reads back timing register bits 6..0 with bit 7 as zero. Unwritten bits are ignored, and any other address reads 00h.
- R10: `syncOe` equals I/O register bit 0. `blankOe` is the inverse of I/O register bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register address (04h I/O control, 05h timing control) |
| regWrData | input | 8 | Register write data |
| regWr | input | 1 | Write strobe, one clock per write |
| regRdData | output | 8 | Readback of the addressed register |
| hSync | output | 1 | Horizontal sync |
| hBlank | output | 1 | Horizontal blanking |
| vSync | output | 1 | Vertical sync |
| vBlank | output | 1 | Vertical blanking |
| field | output | 1 | Field identity |
| syncOe | output | 1 | Output enable for the sync pins |
| blankOe | output | 1 | Output enable for the blank and field pins |

## Verification
The embedded assertions check several properties on every clock. The horizontal count stays below the line length. The field flag moves only at a field end, and the line count returns to zero there. The active shift stays fixed between line boundaries. Vertical sync never appears outside vertical blanking. The I/O register changes only on a write to its address. The exact placement of the shifted blanking window, the three field lengths, the polarity and enable mapping, and the readback masking can be shown only by the bench's scenarios. The bench compares all outputs on every clock against its own timing model across register writes made in the middle of a line.

// File: rtl/vidTimingPkg.sv
package vidTimingPkg;

  // Settings handed from the register block to the timing datapath
  typedef struct packed {
    logic              hPol;
    logic              vPol;
    logic              fPol;
    logic signed [5:0] hShift;
    logic [7:0]        vTotal;
  } ctrlBus_t;

  // Sign-magnitude shift code: bit 4 is the sign, bits 3..0 the magnitude
  function automatic logic signed [5:0] decodeShift(input logic [4:0] code);
    logic signed [5:0] mag;
    mag = $signed({2'b00, code[3:0]});
    return code[4] ? -mag : mag;
  endfunction

  // Field length selection; the reserved code falls back to the default
  function automatic logic [7:0] decodeVTotal(input logic [1:0] code);
    case (code)
      2'b01:   return 8'd241;
      2'b10:   return 8'd242;
      default: return 8'd240;
    endcase
  endfunction

endpackage

// File: rtl/vidTimingCtrl.sv
module vidTimingCtrl
  import vidTimingPkg::*;
#(
  parameter logic [7:0] ADDR_IO = 8'h04,
  parameter logic [7:0] ADDR_TM = 8'h05
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       regWr,
  output logic [7:0] regRdData,
  output logic       syncOe,
  output logic       blankOe,
  output ctrlBus_t   cfg
);

  logic [4:0] ioReg;
  logic [6:0] tmReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ioReg <= '0;
      tmReg <= '0;
    end else if (regWr) begin
      if (regAddr == ADDR_IO) ioReg <= regWrData[4:0];
      if (regAddr == ADDR_TM) tmReg <= regWrData[6:0];
    end
  end

  always_comb begin
    if (regAddr == ADDR_IO)      regRdData = {3'b000, ioReg};
    else if (regAddr == ADDR_TM) regRdData = {1'b0, tmReg};
    else                         regRdData = 8'h00;
  end

  assign syncOe      = ioReg[0];
  assign blankOe     = ~ioReg[1];
  assign cfg.hPol    = ioReg[2];
  assign cfg.vPol    = ioReg[3];
  assign cfg.fPol    = ioReg[4];
  assign cfg.hShift  = decodeShift(tmReg[4:0]);
  assign cfg.vTotal  = decodeVTotal(tmReg[6:5]);

  AST_IO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && regAddr == ADDR_IO) |=> $stable(ioReg)); // R9

endmodule

// File: rtl/vidTimingPath.sv
module vidTimingPath
  import vidTimingPkg::*;
#(
  parameter int LINE_LEN     = 858,
  parameter int HBLANK_START = 720,
  parameter int HBLANK_WIDTH = 138,
  parameter int HSYNC_START  = 736,
  parameter int HSYNC_WIDTH  = 64,
  parameter int VBLANK_LINES = 20,
  parameter int VSYNC_LINES  = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctrlBus_t cfg,
  output logic     hSync,
  output logic     hBlank,
  output logic     vSync,
  output logic     vBlank,
  output logic     field
);

  localparam int HW = $clog2(LINE_LEN);
  localparam logic [HW-1:0] H_LAST = HW'(LINE_LEN - 1);

  logic [HW-1:0]     hCnt;
  logic [7:0]        vCnt;
  logic              fieldOdd;
  logic signed [5:0] actShift;
  logic [7:0]        actVTotal;
  logic              lineEnd;
  logic              frameEnd;
  logic              hSyncRaw, hBlankRaw, vSyncRaw, vBlankRaw;

  assign lineEnd  = (hCnt == H_LAST);
  assign frameEnd = lineEnd && (vCnt >= actVTotal - 8'd1);

  // Counters and line-boundary loading of the timing settings
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hCnt      <= '0;
      vCnt      <= '0;
      fieldOdd  <= 1'b1;
      actShift  <= '0;
      actVTotal <= 8'd240;
    end else begin
      hCnt <= lineEnd ? '0 : hCnt + HW'(1);
      if (lineEnd) begin
        vCnt      <= frameEnd ? 8'd0 : vCnt + 8'd1;
        actShift  <= cfg.hShift;
        actVTotal <= cfg.vTotal;
        if (frameEnd) fieldOdd <= ~fieldOdd;
      end
    end
  end

  // Shifted horizontal blanking window, wrapped around the line
  always_comb begin
    int startPos;
    int rel;
    startPos = HBLANK_START + LINE_LEN + int'(actShift);
    if (startPos >= 2 * LINE_LEN) startPos = startPos - 2 * LINE_LEN;
    else if (startPos >= LINE_LEN) startPos = startPos - LINE_LEN;
    rel = int'(hCnt) - startPos;
    if (rel < 0) rel = rel + LINE_LEN;
    hBlankRaw = (rel < HBLANK_WIDTH);
  end

  assign hSyncRaw  = (int'(hCnt) >= HSYNC_START) && (int'(hCnt) < HSYNC_START + HSYNC_WIDTH);
  assign vBlankRaw = (int'(vCnt) < VBLANK_LINES);
  assign vSyncRaw  = (int'(vCnt) < VSYNC_LINES);

  // Registered polarity stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hSync  <= 1'b0;
      hBlank <= 1'b0;
      vSync  <= 1'b0;
      vBlank <= 1'b0;
      field  <= 1'b0;
    end else begin
      hSync  <= hSyncRaw  ^ cfg.hPol;
      hBlank <= hBlankRaw ^ cfg.hPol;
      vSync  <= vSyncRaw  ^ cfg.vPol;
      vBlank <= vBlankRaw ^ cfg.vPol;
      field  <= fieldOdd  ^ cfg.fPol;
    end
  end

  AST_HCNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    int'(hCnt) < LINE_LEN); // R2
  AST_VCNT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (vCnt == 8'd0)); // R4
  AST_VSYNC_IN_VBLANK: assert property (@(posedge clk) disable iff (!rstN)
    vSyncRaw |-> vBlankRaw); // R5
  AST_FIELD_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> $stable(fieldOdd)); // R6
  AST_TIMING_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !lineEnd |=> ($stable(actShift) && $stable(actVTotal))); // R8

endmodule

// File: rtl/vidTimingGen.sv
module vidTimingGen
  import vidTimingPkg::*;
#(
  parameter int LINE_LEN     = 858,
  parameter int HBLANK_START = 720,
  parameter int HBLANK_WIDTH = 138,
  parameter int HSYNC_START  = 736,
  parameter int HSYNC_WIDTH  = 64,
  parameter int VBLANK_LINES = 20,
  parameter int VSYNC_LINES  = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic       regWr,
  output logic [7:0] regRdData,
  output logic       hSync,
  output logic       hBlank,
  output logic       vSync,
  output logic       vBlank,
  output logic       field,
  output logic       syncOe,
  output logic       blankOe
);

  ctrlBus_t cfg;

  vidTimingCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regWr     (regWr),
    .regRdData (regRdData),
    .syncOe    (syncOe),
    .blankOe   (blankOe),
    .cfg       (cfg)
  );

  vidTimingPath #(
    .LINE_LEN     (LINE_LEN),
    .HBLANK_START (HBLANK_START),
    .HBLANK_WIDTH (HBLANK_WIDTH),
    .HSYNC_START  (HSYNC_START),
    .HSYNC_WIDTH  (HSYNC_WIDTH),
    .VBLANK_LINES (VBLANK_LINES),
    .VSYNC_LINES  (VSYNC_LINES)
  ) uPath (
    .clk    (clk),
    .rstN   (rstN),
    .cfg    (cfg),
    .hSync  (hSync),
    .hBlank (hBlank),
    .vSync  (vSync),
    .vBlank (vBlank),
    .field  (field)
  );

endmodule

// File: tb/vidTimingGen_test.sv
module vidTimingGen_test;

  localparam int CLK_PERIOD = 10;
  localparam int L    = 40;
  localparam int HBS  = 30;
  localparam int HBW  = 8;
  localparam int HSS  = 32;
  localparam int HSW  = 4;
  localparam int VBL  = 20;
  localparam int VSL  = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic       regWr = 1'b0;
  logic [7:0] regRdData;
  logic       hSync, hBlank, vSync, vBlank, field, syncOe, blankOe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vidTimingGen #(
    .LINE_LEN(L), .HBLANK_START(HBS), .HBLANK_WIDTH(HBW),
    .HSYNC_START(HSS), .HSYNC_WIDTH(HSW),
    .VBLANK_LINES(VBL), .VSYNC_LINES(VSL)
  ) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .regRdData(regRdData), .hSync(hSync), .hBlank(hBlank),
    .vSync(vSync), .vBlank(vBlank), .field(field), .syncOe(syncOe),
    .blankOe(blankOe)
  );

  // Timing model built from the requirements
  int mH = 0, mV = 0, mShift = 0, mTot = 240;
  logic mOdd = 1'b1;
  logic [4:0] mIo = '0;
  logic [6:0] mTm = '0;
  logic eHS = 0, eHB = 0, eVS = 0, eVB = 0, eF = 0;

  function automatic int shiftOf(input logic [4:0] c);
    int mag = int'(c[3:0]);
    return c[4] ? -mag : mag;
  endfunction

  function automatic int totOf(input logic [1:0] c);
    return (c == 2'b01) ? 241 : (c == 2'b10) ? 242 : 240;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mH = 0; mV = 0; mOdd = 1'b1; mIo = '0; mTm = '0; mShift = 0; mTot = 240;
      eHS = 0; eHB = 0; eVS = 0; eVB = 0; eF = 0;
    end else begin
      int st, rel;
      logic last;
      st  = (((HBS + mShift) % L) + L) % L;
      rel = (((mH - st) % L) + L) % L;
      eHB = (rel < HBW) ^ mIo[2];
      eHS = (mH >= HSS && mH < HSS + HSW) ^ mIo[2];
      eVB = (mV < VBL) ^ mIo[3];
      eVS = (mV < VSL) ^ mIo[3];
      eF  = mOdd ^ mIo[4];
      if (mH == L - 1) begin
        mH = 0;
        last = (mV >= mTot - 1);
        mV = last ? 0 : mV + 1;
        if (last) mOdd = ~mOdd;
        mShift = shiftOf(mTm[4:0]);
        mTot = totOf(mTm[6:5]);
      end else begin
        mH = mH + 1;
      end
      if (regWr && regAddr == 8'h04) mIo = regWrData[4:0];
      if (regWr && regAddr == 8'h05) mTm = regWrData[6:0];
    end
  end

  task automatic checkCycles(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [6:0] act, exp;
      @(negedge clk);
      act = {hSync, hBlank, vSync, vBlank, field, syncOe, blankOe};
      exp = {eHS, eHB, eVS, eVB, eF, mIo[0], ~mIo[1]};
      checks++;
      if (act !== exp) begin
        errors++;
        if (errors < 20)
          $display("FAIL %s outputs actual %b expected %b at %0t", tag, act, exp, $time);
      end
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic readCheck(input logic [7:0] a, input logic [7:0] exp, input string tag);
    regAddr = a;
    #1;
    checks++;
    if (regRdData !== exp) begin
      errors++;
      $display("FAIL %s readback %h actual %h expected %h", tag, a, regRdData, exp);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    checkCycles(4, "R1 reset outputs");
    readCheck(8'h04, 8'h00, "R1 io reg");
    readCheck(8'h05, 8'h00, "R1 timing reg");
    @(negedge clk);
    rstN = 1'b1;
    checkCycles(2, "R1 first line");
  endtask

  task automatic testNominal();
    checkCycles(L * 25, "R2 R5 R6 nominal");
  endtask

  task automatic testPolarity();
    writeReg(8'h04, 8'hFF);
    readCheck(8'h04, 8'h1F, "R9 io masked");
    checkCycles(L * 2, "R7 R10 all inverted");
    writeReg(8'h04, 8'h08);
    checkCycles(L, "R7 vertical only");
    writeReg(8'h04, 8'h16);
    checkCycles(L, "R6 R7 R10 field and horizontal");
    writeReg(8'h07, 8'h55);
    readCheck(8'h07, 8'h00, "R9 other address");
    checkCycles(L, "R9 other address ignored");
    writeReg(8'h04, 8'h00);
    checkCycles(L, "R7 restored");
  endtask

  task automatic testShift();
    logic [7:0] codes [6] = '{8'h0F, 8'h1F, 8'h10, 8'h05, 8'h13, 8'h00};
    for (int i = 0; i < 6; i++) begin
      checkCycles(L / 2 + i, "R8 mid-line");
      writeReg(8'h05, codes[i]);
      readCheck(8'h05, codes[i], "R9 timing readback");
      checkCycles(L * 3, "R3 R8 shift");
    end
    writeReg(8'h05, 8'h80);
    readCheck(8'h05, 8'h00, "R9 timing bit 7 masked");
  endtask

  task automatic testVertical();
    logic [7:0] codes [4] = '{8'h20, 8'h40, 8'h60, 8'h00};
    for (int i = 0; i < 4; i++) begin
      writeReg(8'h05, codes[i]);
      checkCycles(L * 485, "R4 R6 field length");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testNominal();
    testPolarity();
    testShift();
    testVertical();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule